// File: doc/BRIEF.md
# Programmable Divider with Offset Adder

This block divides a clock taken from an oscillator loop by a programmable ratio and marks every completed division with a one-cycle strobe. A down-counter runs on the divided clock itself. Each time it reaches its terminal state, it loads a fresh divide value and starts another period.

The divide value is the programmed word, optionally shifted by a fixed offset. A select input decides whether the offset is added. With the select low, the offset is added and the sum wraps modulo 2^W. With the select high, the word is used as it is. This lets a transceiver move its oscillator frequency by the intermediate frequency between receive and transmit without reprogramming the word.

The word and the select are sampled only at the reload instant. The ratio latched at that instant is presented on an output so that it can be observed.

Top module: `offset_divider`

## Requirements
- R1: While `rst_i` is high at a clock edge, `fv_o` and `ratio_o` are 0 after that edge.
- R2: When `tr_i` is 1 at a reload, the latched ratio shown on `ratio_o` equals `n_i`.
- R3: When `tr_i` is 0 at a reload, the latched ratio equals (`n_i` + OFFSET) mod 2^W (856 by default), so a sum beyond W bits wraps.
- R4: For a latched ratio E of 2 or more, `fv_o` is high for exactly one cycle in every E cycles.
- R5: A latched ratio of 0 or 1 divides by one: `fv_o` stays high on every cycle.
- R6: Changes on `n_i` or `tr_i` between reloads have no effect until the next `fv_o` pulse. `ratio_o` changes only on the cycle on which `fv_o` is high.
- R7: The first clock edge with `rst_i` low is a reload, so `fv_o` is high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| n_i | input | W (14) | Programmed divide word, bit 0 least significant |
| tr_i | input | 1 | Offset select: 0 adds OFFSET, 1 uses `n_i` as is |
| fv_o | output | 1 | Registered strobe, high on the cycle of each reload |
| ratio_o | output | W (14) | Divide ratio latched at the last reload |

## Verification
On every cycle, the assertions check the following:
- A pulse for a ratio of two or more is followed by a low cycle.
- A ratio of 0 or 1 keeps the strobe high.
- The latched ratio never moves without a strobe.
- A word at or above the wrap point, with the offset applied, yields a value below the offset.

The exact pulse spacing is shown only by the bench's sweeps, which cover every word and select value of a 6-bit configuration plus wrap-point words at full width. The same holds for the ratio matching the arithmetic sum and for the first pulse right after reset. Only a scenario can show that words changed mid-period are deferred to the following reload.

// File: rtl/offdiv_pkg.sv
package offdiv_pkg;
  localparam int DEF_W      = 14;
  localparam int DEF_OFFSET = 856;
endpackage

// File: rtl/offdiv_offset_add.sv
module offdiv_offset_add #(
  parameter int W      = offdiv_pkg::DEF_W,
  parameter int OFFSET = offdiv_pkg::DEF_OFFSET
) (
  input  logic [W-1:0] n_i,
  input  logic         tr_i,
  output logic [W-1:0] eff_o
);
  localparam logic [W-1:0] OFF_W = W'(OFFSET);

  generate
    if (OFFSET == 0) begin : g_bypass
      always_comb eff_o = n_i;
      logic unused_tr;
      always_comb unused_tr = tr_i;
    end else begin : g_add
      // truncating add: the sum wraps modulo 2^W
      always_comb eff_o = tr_i ? n_i : (n_i + OFF_W);
    end
  endgenerate
endmodule

// File: rtl/offdiv_down_cnt.sv
module offdiv_down_cnt #(
  parameter int W = offdiv_pkg::DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] eff_i,
  output logic         fv_o,
  output logic [W-1:0] ratio_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] ratio_q;
  logic         fv_q;
  logic         term;

  always_comb term = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      fv_q    <= 1'b0;
    end else begin
      fv_q <= term;
      if (term) begin
        ratio_q <= eff_i;
        cnt_q   <= (eff_i <= ONE) ? '0 : (eff_i - ONE);
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  always_comb begin
    fv_o    = fv_q;
    ratio_o = ratio_q;
  end

  // R4
  fv_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (fv_q && ratio_q > ONE) |=> !fv_q);

  // R5
  unit_ratio_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (fv_q && ratio_q <= ONE) |=> fv_q);

  // R6
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !fv_q |-> $stable(ratio_q));
endmodule

// File: rtl/offset_divider.sv
module offset_divider #(
  parameter int W      = offdiv_pkg::DEF_W,
  parameter int OFFSET = offdiv_pkg::DEF_OFFSET
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] n_i,
  input  logic         tr_i,
  output logic         fv_o,
  output logic [W-1:0] ratio_o
);
  logic [W-1:0] eff_w;

  offdiv_offset_add #(.W(W), .OFFSET(OFFSET)) add_i (
    .n_i   (n_i),
    .tr_i  (tr_i),
    .eff_o (eff_w)
  );

  offdiv_down_cnt #(.W(W)) cnt_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .eff_i   (eff_w),
    .fv_o    (fv_o),
    .ratio_o (ratio_o)
  );

  generate
    if (OFFSET > 0) begin : g_wrap_chk
      localparam logic [W-1:0] WRAP_AT = W'((1 << W) - OFFSET);
      localparam logic [W-1:0] OFF_W   = W'(OFFSET);
      // R3
      wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tr_i && n_i >= WRAP_AT) |-> (eff_w < OFF_W));
    end
  endgenerate
endmodule

// File: tb/offset_divider_tb_top.sv
module offset_divider_tb_top;
  localparam int SW = 6;
  localparam int SOFF = 13;
  localparam int BW = 14;
  localparam int BOFF = 856;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] n_s = '0;
  logic tr_s = 1'b1;
  logic fv_s;
  logic [SW-1:0] ratio_s;
  logic [BW-1:0] n_b = '0;
  logic tr_b = 1'b1;
  logic fv_b;
  logic [BW-1:0] ratio_b;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  offset_divider #(.W(SW), .OFFSET(SOFF)) small_i (
    .clk_i(clk), .rst_i(rst), .n_i(n_s), .tr_i(tr_s),
    .fv_o(fv_s), .ratio_o(ratio_s));

  offset_divider dut_i (
    .clk_i(clk), .rst_i(rst), .n_i(n_b), .tr_i(tr_b),
    .fv_o(fv_b), .ratio_o(ratio_b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int get_fv(input bit big);
    return big ? int'(fv_b) : int'(fv_s);
  endfunction

  function automatic int get_ratio(input bit big);
    return big ? int'(ratio_b) : int'(ratio_s);
  endfunction

  task automatic run_case(input bit big, input int n, input bit tr);
    int w;
    int off;
    int eff;
    int e;
    int bad_fv;
    int bad_r;
    int act_fv;
    int exp_fv;
    int act_r;
    w = big ? BW : SW;
    off = big ? BOFF : SOFF;
    if (big) begin
      n_b = BW'(n);
      tr_b = tr;
    end else begin
      n_s = SW'(n);
      tr_s = tr;
    end
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    eff = tr ? n : ((n + off) % (1 << w));
    e = (eff <= 1) ? 1 : eff;
    bad_fv = 0;
    bad_r = 0;
    act_fv = 0;
    exp_fv = 0;
    act_r = 0;
    for (int c = 1; c <= 2 * e + 2; c++) begin
      @(negedge clk);
      if (c == 1) check(get_fv(big) == 1, "R7", get_fv(big), 1);
      if (get_fv(big) != ((((c - 1) % e) == 0) ? 1 : 0) && bad_fv == 0) begin
        bad_fv = 1;
        act_fv = get_fv(big);
        exp_fv = (((c - 1) % e) == 0) ? 1 : 0;
      end
      if (get_ratio(big) != eff && bad_r == 0) begin
        bad_r = 1;
        act_r = get_ratio(big);
      end
    end
    check(bad_fv == 0, (eff <= 1) ? "R5" : "R4", act_fv, exp_fv);
    check(bad_r == 0, tr ? "R2" : "R3", act_r, eff);
  endtask

  initial begin
    // R1: reset state on both configurations
    @(negedge clk);
    @(negedge clk);
    check(fv_s == 1'b0, "R1", int'(fv_s), 0);
    check(ratio_s == '0, "R1", int'(ratio_s), 0);
    check(fv_b == 1'b0, "R1", int'(fv_b), 0);
    check(ratio_b == '0, "R1", int'(ratio_b), 0);

    // exhaustive small sweep: R2, R3, R4, R5, R7
    for (int n = 0; n < (1 << SW); n++) begin
      run_case(1'b0, n, 1'b1);
      run_case(1'b0, n, 1'b0);
    end

    // full width: wrap points, unit ratios, defaults
    run_case(1'b1, 16383, 1'b0);  // R3 wraps to 855
    run_case(1'b1, 15528, 1'b0);  // R3/R5 wraps to 0
    run_case(1'b1, 15529, 1'b0);  // wraps to 1
    run_case(1'b1, 0, 1'b1);      // R5 ratio 0
    run_case(1'b1, 100, 1'b0);    // R3 956
    run_case(1'b1, 16383, 1'b1);  // R2 all ones, no offset

    // R6: mid-period changes deferred to the next reload
    n_s = SW'(20);
    tr_s = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    begin
      int bad;
      int a_fv;
      int a_r;
      int x_fv;
      int x_r;
      bad = 0;
      a_fv = 0;
      a_r = 0;
      x_fv = 0;
      x_r = 0;
      for (int c = 1; c <= 50; c++) begin
        int ef;
        int er;
        @(negedge clk);
        ef = (c == 1 || c == 21 || c == 26 || c == 44) ? 1 : 0;
        er = (c < 21) ? 20 : ((c < 26) ? 5 : 18);
        if (bad == 0 && (int'(fv_s) != ef || int'(ratio_s) != er)) begin
          bad = c;
          a_fv = int'(fv_s);
          a_r = int'(ratio_s);
          x_fv = ef;
          x_r = er;
        end
        if (c == 5) n_s = SW'(5);
        if (c == 23) tr_s = 1'b0;
      end
      check(bad == 0, "R6 strobe", a_fv, x_fv);
      check(bad == 0, "R6 ratio", a_r, x_r);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule